// File: doc/BRIEF.md
# SDRAM Write Burst Truncation Sequencer

This block sits on the command side of a single-data-rate SDRAM controller. It accepts one write request at a time and puts a WRITE command on the bus to the requested bank and column. It then drives the data-output enable for the write beats and ends the burst in one of three ways. The burst may run out naturally. It may be cut short by a READ to any bank. It may also be cut short by a PRECHARGE to the bank that was written. The block drives the chip-select, row-strobe, column-strobe and write-enable lines as a 4-bit command, together with the bank, the address, the data-output enable and the data mask.

Every timing rule is counted in whole clock cycles: write recovery before a precharge, row precharge time before the next access to that bank, and CAS latency for the read that truncates a burst. Each bank has its own lockout counter. A request that targets a bank still recovering waits with `req_ready` low. A request to any other bank is accepted as soon as the sequencer is idle. A per-bank done pulse marks the first cycle in which a new request to that bank can be accepted.

Top module: `sdram_wr_trunc_seq`

## Requirements
- R1: After synchronous reset, the command is NOP, bank and address are zero, `dq_oe`, `dqm`, `rd_valid` and every `bank_done` bit are low, and `req_ready` is high.
- R2: A request accepted at a clock edge (valid and ready both high) puts a WRITE on the bus in the next cycle. That WRITE carries the request bank on `ba`, the column on `addr[COL_W-1:0]`, and the effective auto-precharge flag on `addr[10]`, with all other address bits zero.
- R3: The command is driven as {cs_n, ras_n, cas_n, we_n}: NOP=0111, READ=0101, WRITE=0100, PRECHARGE=0010. Every cycle without a command shows NOP with `ba` and `addr` at zero.
- R4: `req_blen` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats, and code 7 selects a full page of 2^COL_W beats. An untruncated fixed burst holds `dq_oe` high for exactly that many consecutive cycles, starting with the WRITE cycle.
- R5: With `req_trunc`=1 (read), the sequencer keeps K beats, where K is `req_keep` clamped to the range 1 to the burst length (page size for a full page). It issues READ K cycles after the WRITE, carrying `req_rd_bank`, with `req_rd_col` on the address and `addr[10]` low. `dq_oe` is low from the READ cycle on.
- R6: `rd_valid` is high for exactly one cycle, CAS_LAT cycles after a READ.
- R7: With `req_trunc`=2 (precharge) on a fixed burst without auto precharge, the sequencer keeps K beats as in R5. It issues PRECHARGE to the written bank, with `addr[10]` low, T_WR cycles after the last kept beat.
- R8: During precharge truncation, `dqm` is high in every cycle from the first unwanted beat through the PRECHARGE cycle, which includes the cycle before and the cycle of the PRECHARGE. `dq_oe` is low in those cycles.
- R9: Auto precharge takes effect only for fixed bursts that are not truncated by a READ. When it is in effect, a precharge truncation request is ignored: the full burst runs, no PRECHARGE is issued, and the bank is locked until T_WR+T_RP cycles after its last beat.
- R10: A full-page burst without read truncation always ends with PRECHARGE, placed as in R7 after K beats. The auto-precharge request is ignored for full-page bursts.
- R11: After a PRECHARGE in cycle P, a request to that bank is not accepted before cycle P+T_RP-1, so its WRITE comes no earlier than P+T_RP. `bank_done` for that bank pulses in cycle P+T_RP-1. An auto-precharged bank instead pulses one cycle before its lock ends.
- R12: While a bank is locked, a request to another bank is accepted. A read-truncated request whose `req_rd_bank` is locked is held off.
- R13: `req_ready` is low from the WRITE cycle through the burst's last command cycle. A burst that leaves its bank open pulses `bank_done` for that bank in the cycle after its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_bank | input | BANK_W | Bank to write |
| req_col | input | COL_W | Start column |
| req_blen | input | 3 | Burst length code (0..3 fixed, 7 full page) |
| req_trunc | input | 2 | End type: 0 natural, 1 read, 2 precharge |
| req_ap | input | 1 | Auto precharge requested |
| req_keep | input | COL_W+1 | Beats to keep before truncation |
| req_rd_bank | input | BANK_W | Bank for the truncating READ |
| req_rd_col | input | COL_W | Column for the truncating READ |
| cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address bus, bit 10 is the precharge/auto-precharge flag |
| dq_oe | output | 1 | Write data driven this cycle |
| dqm | output | 1 | Data mask |
| rd_valid | output | 1 | First read data beat expected |
| bank_done | output | NBANK | Per-bank pulse: bank accepts requests again |

## Verification
The sweep covers every burst length and every end type, with and without auto precharge, and every keep count from zero to one above the limit. Off-by-one placement is the main target. A sequencer that counts write recovery from the wrong beat puts PRECHARGE a cycle early or late. One that masks only the PRECHARGE edge leaves the beat before it written. One that keeps `dq_oe` high in the READ cycle drives data into a read. Clamping faults show up as a keep count of zero producing a burst with no beats, or as a keep count that exceeds the burst length running past it. Directed cases hold a locked bank while a request to a neighbouring bank proceeds. They also hold off a read truncation that targets the locked bank, which a design sharing one lock across banks, or ignoring the read bank, would get wrong.

// File: rtl/sdram_trunc_pkg.sv
package sdram_trunc_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_PRE   = 4'b0010
  } cmd_e;

  typedef enum logic [1:0] {
    END_NATURAL = 2'd0,
    END_READ    = 2'd1,
    END_PRE     = 2'd2
  } end_e;

  localparam logic [1:0] TR_NONE = 2'd0;
  localparam logic [1:0] TR_READ = 2'd1;
  localparam logic [1:0] TR_PRE  = 2'd2;

  localparam int A10_BIT = 10;

endpackage

// File: rtl/sdram_plan_decode.sv
module sdram_plan_decode
  import sdram_trunc_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int T_WR  = 2,
  parameter int T_RP  = 3,
  parameter int CNT_W = COL_W + 1,
  parameter int T_W   = 10
) (
  input  logic [2:0]       blen,
  input  logic [1:0]       trunc,
  input  logic             ap,
  input  logic [CNT_W-1:0] keep,
  output logic             ap_eff,
  output end_e             kind,
  output logic [T_W-1:0]   n_beats,
  output logic [T_W-1:0]   end_idx,
  output logic [T_W-1:0]   rel_val
);

  localparam int PAGE = 1 << COL_W;

  logic           full;
  logic [T_W-1:0] lim;
  logic [T_W-1:0] kc;

  always_comb begin
    full = (blen > 3'd3);
    case (blen)
      3'd0:    lim = T_W'(1);
      3'd1:    lim = T_W'(2);
      3'd2:    lim = T_W'(4);
      3'd3:    lim = T_W'(8);
      default: lim = T_W'(PAGE);
    endcase

    kc = T_W'(keep);
    if (kc == '0) kc = T_W'(1);
    if (kc > lim) kc = lim;

    ap_eff = ap && !full && (trunc != TR_READ);

    if (trunc == TR_READ) begin
      kind    = END_READ;
      n_beats = kc;
      end_idx = kc;
      rel_val = T_W'(1);
    end else if (full || (trunc == TR_PRE && !ap_eff)) begin
      kind    = END_PRE;
      n_beats = kc;
      end_idx = kc - T_W'(1) + T_W'(T_WR);
      rel_val = T_W'(T_RP - 1);
    end else begin
      kind    = END_NATURAL;
      n_beats = lim;
      end_idx = lim - T_W'(1);
      rel_val = ap_eff ? T_W'(T_WR + T_RP - 1) : T_W'(1);
    end
  end

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_trunc_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int T_W    = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [COL_W-1:0]  in_col,
  input  logic [BANK_W-1:0] in_rd_bank,
  input  logic [COL_W-1:0]  in_rd_col,
  input  logic              in_ap,
  input  end_e              in_kind,
  input  logic [T_W-1:0]    in_n,
  input  logic [T_W-1:0]    in_end,
  input  logic [T_W-1:0]    in_rel,
  output logic [3:0]        cmd_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dq_oe,
  output logic              dqm,
  output logic              rd_issue,
  output logic              busy,
  output logic              rel_fire,
  output logic [BANK_W-1:0] rel_bank,
  output logic [T_W-1:0]    rel_val
);

  logic              busy_q, busy_d;
  logic [T_W-1:0]    t_q, t_d;
  logic [BANK_W-1:0] bank_q, rdb_q;
  logic [COL_W-1:0]  rdc_q;
  end_e              kind_q;
  logic [T_W-1:0]    n_q, end_q, rel_q;

  logic [3:0]        cmd_d;
  logic [BANK_W-1:0] ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic              oe_d, dqm_d;

  always_comb begin
    busy_d = busy_q;
    t_d    = t_q;
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    oe_d   = 1'b0;
    dqm_d  = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      t_d    = '0;
      cmd_d  = CMD_WRITE;
      ba_d   = in_bank;
      addr_d[COL_W-1:0] = in_col;
      addr_d[A10_BIT]   = in_ap;
      oe_d   = 1'b1;
    end else if (busy_q) begin
      if (t_q == end_q) begin
        busy_d = 1'b0;
      end else begin
        t_d   = t_q + T_W'(1);
        oe_d  = (t_d < n_q);
        dqm_d = (kind_q == END_PRE) && (t_d >= n_q);
        if (t_d == end_q && kind_q == END_READ) begin
          cmd_d  = CMD_READ;
          ba_d   = rdb_q;
          addr_d[COL_W-1:0] = rdc_q;
        end else if (t_d == end_q && kind_q == END_PRE) begin
          cmd_d  = CMD_PRE;
          ba_d   = bank_q;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      t_q      <= '0;
      cmd_n    <= CMD_NOP;
      ba       <= '0;
      addr     <= '0;
      dq_oe    <= 1'b0;
      dqm      <= 1'b0;
      rd_issue <= 1'b0;
      bank_q   <= '0;
      rdb_q    <= '0;
      rdc_q    <= '0;
      kind_q   <= END_NATURAL;
      n_q      <= '0;
      end_q    <= '0;
      rel_q    <= '0;
    end else begin
      busy_q   <= busy_d;
      t_q      <= t_d;
      cmd_n    <= cmd_d;
      ba       <= ba_d;
      addr     <= addr_d;
      dq_oe    <= oe_d;
      dqm      <= dqm_d;
      rd_issue <= (cmd_d == CMD_READ);
      if (start) begin
        bank_q <= in_bank;
        rdb_q  <= in_rd_bank;
        rdc_q  <= in_rd_col;
        kind_q <= in_kind;
        n_q    <= in_n;
        end_q  <= in_end;
        rel_q  <= in_rel;
      end
    end
  end

  assign busy     = busy_q;
  assign rel_fire = busy_q && (t_q == end_q);
  assign rel_bank = bank_q;
  assign rel_val  = rel_q;

  // R13
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int T_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [T_W-1:0] val,
  output logic           lock,
  output logic           done
);

  logic [T_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - T_W'(1);
  end

  assign lock = (cnt > T_W'(1));
  assign done = (cnt == T_W'(1));

  // R11
  load_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (load && val > T_W'(1)) |=> lock);

  // R11
  done_last_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> (!lock && !done));

endmodule

// File: rtl/sdram_wr_trunc_seq.sv
module sdram_wr_trunc_seq
  import sdram_trunc_pkg::*;
#(
  parameter int NBANK   = 4,
  parameter int COL_W   = 8,
  parameter int ADDR_W  = 12,
  parameter int T_WR    = 2,
  parameter int T_RP    = 3,
  parameter int CAS_LAT = 2,
  localparam int BANK_W = $clog2(NBANK),
  localparam int CNT_W  = COL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [2:0]        req_blen,
  input  logic [1:0]        req_trunc,
  input  logic              req_ap,
  input  logic [CNT_W-1:0]  req_keep,
  input  logic [BANK_W-1:0] req_rd_bank,
  input  logic [COL_W-1:0]  req_rd_col,
  output logic [3:0]        cmd_n,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              dq_oe,
  output logic              dqm,
  output logic              rd_valid,
  output logic [NBANK-1:0]  bank_done
);

  localparam int PAGE = 1 << COL_W;
  localparam int T_W  = $clog2(PAGE + T_WR + T_RP + 2) + 1;

  logic              ap_eff;
  end_e              kind;
  logic [T_W-1:0]    n_beats, end_idx, rel_val_in;
  logic              busy, rel_fire, rd_issue, start;
  logic [BANK_W-1:0] rel_bank;
  logic [T_W-1:0]    rel_val;
  logic [NBANK-1:0]  lock;
  logic [CAS_LAT-1:0] rd_pipe;

  sdram_plan_decode #(
    .COL_W(COL_W), .T_WR(T_WR), .T_RP(T_RP), .CNT_W(CNT_W), .T_W(T_W)
  ) u_dec (
    .blen(req_blen), .trunc(req_trunc), .ap(req_ap), .keep(req_keep),
    .ap_eff(ap_eff), .kind(kind), .n_beats(n_beats), .end_idx(end_idx),
    .rel_val(rel_val_in)
  );

  assign req_ready = !busy && !lock[req_bank] &&
                     !(req_trunc == TR_READ && lock[req_rd_bank]);
  assign start = req_valid && req_ready;

  sdram_burst_seq #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .T_W(T_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .in_bank(req_bank), .in_col(req_col),
    .in_rd_bank(req_rd_bank), .in_rd_col(req_rd_col),
    .in_ap(ap_eff), .in_kind(kind), .in_n(n_beats), .in_end(end_idx),
    .in_rel(rel_val_in),
    .cmd_n(cmd_n), .ba(ba), .addr(addr), .dq_oe(dq_oe), .dqm(dqm),
    .rd_issue(rd_issue), .busy(busy), .rel_fire(rel_fire),
    .rel_bank(rel_bank), .rel_val(rel_val)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sdram_bank_timer #(.T_W(T_W)) u_tmr (
      .clk(clk), .rst(rst),
      .load(rel_fire && (rel_bank == BANK_W'(b))),
      .val(rel_val),
      .lock(lock[b]),
      .done(bank_done[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pipe <= '0;
    end else begin
      rd_pipe[0] <= rd_issue;
      for (int i = 1; i < CAS_LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
    end
  end
  assign rd_valid = rd_pipe[CAS_LAT-1];

  // R2
  accept_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd_n == CMD_WRITE));

  // R5
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_READ) |-> !dq_oe);

  // R8
  pre_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_PRE) |-> (dqm && $past(dqm)));

  // R11
  pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (T_RP > 2 && cmd_n == CMD_PRE) |=> !(req_ready && req_bank == $past(ba)));

  // R13
  write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_n == CMD_WRITE) |-> !req_ready);

endmodule

// File: tb/tb_sdram_wr_trunc_seq.sv
module tb_sdram_wr_trunc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 4, COL_W = 4, ADDR_W = 12;
  localparam int T_WR = 2, T_RP = 3, CAS_LAT = 2;
  localparam int BANK_W = 2, CNT_W = COL_W + 1, PAGE = 1 << COL_W;
  localparam logic [3:0] C_NOP = 4'b0111, C_RD = 4'b0101, C_WR = 4'b0100, C_PRE = 4'b0010;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [BANK_W-1:0] req_bank = '0, req_rd_bank = '0, ba;
  logic [COL_W-1:0] req_col = '0, req_rd_col = '0;
  logic [2:0] req_blen = '0;
  logic [1:0] req_trunc = '0;
  logic req_ap = 1'b0;
  logic [CNT_W-1:0] req_keep = '0;
  logic [3:0] cmd_n;
  logic [ADDR_W-1:0] addr;
  logic dq_oe, dqm, rd_valid;
  logic [NBANK-1:0] bank_done;

  int errors = 0, checks = 0;
  bit finished = 0;

  sdram_wr_trunc_seq #(.NBANK(NBANK), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .T_WR(T_WR), .T_RP(T_RP), .CAS_LAT(CAS_LAT)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_blen(req_blen),
    .req_trunc(req_trunc), .req_ap(req_ap), .req_keep(req_keep),
    .req_rd_bank(req_rd_bank), .req_rd_col(req_rd_col),
    .cmd_n(cmd_n), .ba(ba), .addr(addr), .dq_oe(dq_oe), .dqm(dqm),
    .rd_valid(rd_valid), .bank_done(bank_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_one(input logic [2:0] bc, input logic [1:0] tr, input bit ap,
                         input int keep, input int bank, input int col,
                         input int rdb, input int rdc);
    int bl, lim, kc, n, e, v, tmax, w;
    bit fp, ap_e, rd_e, pre_e;
    logic [3:0] ec;
    logic [BANK_W-1:0] eb;
    logic [ADDR_W-1:0] ea;
    logic eoe, edqm;
    string tag;
    fp   = (bc == 3'd7);
    bl   = fp ? PAGE : (1 << bc);
    lim  = bl;
    kc   = (keep < 1) ? 1 : ((keep > lim) ? lim : keep);
    ap_e = ap && !fp && (tr != 2'd1);
    rd_e = (tr == 2'd1);
    pre_e = !rd_e && (fp || (tr == 2'd2 && !ap_e));
    if (rd_e)       begin n = kc; e = kc;            v = 1; end
    else if (pre_e) begin n = kc; e = kc - 1 + T_WR; v = T_RP - 1; end
    else            begin n = bl; e = bl - 1;        v = ap_e ? T_WR + T_RP - 1 : 1; end
    tmax = e + v + CAS_LAT + 1;

    @(negedge clk);
    req_bank = BANK_W'(bank); req_col = COL_W'(col); req_blen = bc;
    req_trunc = tr; req_ap = ap; req_keep = CNT_W'(keep);
    req_rd_bank = BANK_W'(rdb); req_rd_col = COL_W'(rdc); req_valid = 1'b1;
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    @(posedge clk); #1;
    req_valid = 1'b0; req_trunc = 2'd0;

    for (int t = 0; t <= tmax; t++) begin
      @(negedge clk);
      ec = C_NOP; eb = '0; ea = '0;
      eoe = (t <= e) && (t < n);
      edqm = pre_e && (t <= e) && (t >= n);
      if (t == 0) begin
        ec = C_WR; eb = BANK_W'(bank); ea[COL_W-1:0] = COL_W'(col); ea[10] = ap_e;
      end else if (t == e && rd_e) begin
        ec = C_RD; eb = BANK_W'(rdb); ea[COL_W-1:0] = COL_W'(rdc);
      end else if (t == e && pre_e) begin
        ec = C_PRE; eb = BANK_W'(bank);
      end
      if (t == 0) tag = "R2";
      else if (t > e) tag = "R3";
      else if (rd_e) tag = "R5";
      else if (pre_e) tag = fp ? "R10" : "R7";
      else if (ap_e) tag = "R9";
      else tag = "R4";
      chk({cmd_n, ba, addr, dq_oe} == {ec, eb, ea, eoe}, tag,
          32'({cmd_n, ba, addr, dq_oe}), 32'({ec, eb, ea, eoe}));
      chk(dqm == edqm, "R8", 32'(dqm), 32'(edqm));
      chk(req_ready == (t >= e + v), (t <= e) ? "R13" : "R11",
          32'(req_ready), 32'(t >= e + v));
      chk(bank_done == ((t == e + v) ? NBANK'(1 << bank) : '0),
          (pre_e || ap_e) ? "R11" : "R13", 32'(bank_done),
          32'((t == e + v) ? (1 << bank) : 0));
      chk(rd_valid == (rd_e && t == e + CAS_LAT), "R6", 32'(rd_valid),
          32'(rd_e && t == e + CAS_LAT));
    end
  endtask

  task automatic pre_then_probe(input int bank);
    @(negedge clk);
    req_bank = BANK_W'(bank); req_blen = 3'd2; req_trunc = 2'd2; req_ap = 1'b0;
    req_keep = CNT_W'(2); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0; req_trunc = 2'd0;
    repeat (4) @(negedge clk);
    chk(cmd_n == C_PRE, "R7", 32'(cmd_n), 32'(C_PRE));
    @(posedge clk); #1;
  endtask

  int run;
  int codes[5] = '{0, 1, 2, 3, 7};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk({cmd_n, ba, addr} == {C_NOP, 2'b00, 12'h000}, "R1", 32'({cmd_n, ba, addr}), 32'({C_NOP, 14'h0}));
    chk({dq_oe, dqm, rd_valid, bank_done} == '0, "R1", 32'({dq_oe, dqm, rd_valid, bank_done}), 0);
    chk(req_ready == 1'b1, "R1", 32'(req_ready), 1);

    run = 0;
    for (int i = 0; i < 5; i++)
      for (int tr = 0; tr < 3; tr++)
        for (int ap = 0; ap < 2; ap++) begin
          int lim = (codes[i] == 7) ? PAGE : (1 << codes[i]);
          for (int k = 0; k <= lim + 1; k++) begin
            run_one(3'(codes[i]), 2'(tr), ap[0], k, run % NBANK, (run * 3) % PAGE,
                    (run + 1) % NBANK, (run * 5 + 1) % PAGE);
            run++;
          end
        end

    // R12: other bank proceeds during lock of bank 0
    pre_then_probe(0);
    req_bank = 2'd0; #1;
    chk(req_ready == 1'b0, "R12", 32'(req_ready), 0);
    req_bank = 2'd1; req_blen = 3'd0; req_col = 4'd5; req_valid = 1'b1; #1;
    chk(req_ready == 1'b1, "R12", 32'(req_ready), 1);
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk({cmd_n, ba} == {C_WR, 2'd1}, "R12", 32'({cmd_n, ba}), 32'({C_WR, 2'd1}));
    repeat (10) @(negedge clk);

    // R12: read truncation aimed at a locked bank is held off
    pre_then_probe(2);
    req_bank = 2'd3; req_trunc = 2'd1; req_rd_bank = 2'd2; #1;
    chk(req_ready == 1'b0, "R12", 32'(req_ready), 0);
    req_rd_bank = 2'd3; #1;
    chk(req_ready == 1'b1, "R12", 32'(req_ready), 1);
    req_trunc = 2'd0;
    repeat (10) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule